// File: doc/BRIEF.md
# Descriptor-Driven Byte Transfer Controller

This controller copies single bytes between locations on a simple memory bus. The setup for each copy lives in a local table of 24 control records. Software fills the table through a small record port. An activation strobe then names one record. The controller reads that record, copies one byte from the record's source address to its destination address, updates the record and stores it back.

Each record chooses between a one-shot (normal) mode and a looping (repeat) mode. Each record also says whether each of its two addresses steps forward after a copy. A chain flag makes the controller continue with the next record in the table within the same activation. Three outputs report progress: a busy flag for the whole activation, a done pulse when it finishes, and an end-of-count pulse for each record whose count runs out.

Record layout, from the top bit down:

| Bits | Field |
|------|-------|
| 52 | mode: 1 = repeat, 0 = normal |
| 51 | chain |
| 50 | end-of-count enable in repeat mode |
| 49 | source-address step |
| 48 | destination-address step |
| 47:40 | count |
| 39:32 | repeat size |
| 31:16 | source address |
| 15:0 | destination address |

Top module: `xfer_ctl`

## Requirements
- R1: After reset, `busy`, `done`, `eoc` and `mem_req` are low, and every record in the table reads back as zero.
- R2: When `cfg_we` is high and the controller is idle, the record at `cfg_idx` is written with `cfg_wdata`. `cfg_rdata` always shows the record at `cfg_idx`, laid out as in the table above. An index of 24 or more writes nothing and reads zero.
- R3: A high `act_valid` while idle, with `act_idx` below 24, starts an activation at that record, and `busy` is high in the next cycle. A high `act_valid` with an index of 24 or more has no effect, and so has a high `act_valid` while busy.
- R4: Each record processed produces one byte copy. The controller first holds a read of the source address (`mem_req`=1, `mem_we`=0) until `mem_ready` is seen. It then holds a write of that byte to the destination address (`mem_req`=1, `mem_we`=1) until `mem_ready` is seen.
- R5: After a copy, the source address in the record increases by 1 if bit 49 is set and is otherwise unchanged. The destination address does the same under bit 48.
- R6: In normal mode the stored count drops by 1 per copy. When it reaches zero, `eoc` pulses for one cycle at the write-back. A starting count of 0 counts as 256: it becomes 255 and gives no `eoc`.
- R7: In repeat mode, a count that reaches zero is reloaded with the repeat size. Each stepping address is moved back by the repeat size minus one, which restores its starting value; a repeat size of 0 counts as 256. `eoc` pulses only if bit 50 is set.
- R8: If the chain bit of a processed record is 1, the next record is processed in the same activation. The next record is index+1, and index 23 is followed by index 0. Processing stops after the first record whose chain bit is 0.
- R9: `busy` stays high from the cycle after acceptance through the write-back cycle of the last record in the chain. `done` pulses once, in that final write-back cycle, and `busy` is low in the following cycle.
- R10: A write on the record port while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activation strobe |
| act_idx | input | 5 | Record index for activation |
| cfg_we | input | 1 | Record write enable |
| cfg_idx | input | 5 | Record index for write and read-back |
| cfg_wdata | input | 53 | Record write data |
| cfg_rdata | output | 53 | Record at cfg_idx |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_rdata | input | 8 | Bus read data |
| mem_ready | input | 1 | Bus access completes this cycle |
| busy | output | 1 | Activation in progress |
| done | output | 1 | Last write-back of an activation |
| eoc | output | 1 | A record's count ran out (per the mode rules) |

## Verification
Directed cases cover the following:
- a count of one, which tells a normal-mode end apart from a plain decrement;
- a starting count of zero, which separates 256-count wrap from an immediate end;
- repeat records with end-of-count enabled and disabled, which show reload and address restore separately from the `eoc` decision;
- a three-record chain, and a chain that wraps from record 23 to record 0, which test chain order and the single `done`;
- out-of-range activations, activations while busy and record writes while busy, each followed by a read-back that shows no change.

Random records then combine modes, step bits, overlapping addresses and chains under a bus with random wait states. These runs separate correct handshake timing and ordering of dependent copies from mistakes that show up only when records interact.

// File: rtl/xfer_ctl.sv
module xfer_ctl #(
  parameter int NREC = 24,
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int CW   = 8,
  localparam int IW  = $clog2(NREC),
  localparam int RW  = 5 + 2*CW + 2*AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_valid,
  input  logic [IW-1:0] act_idx,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          eoc
);
  localparam logic [IW:0] NLIM = IW'(NREC) == '0 ? {1'b1, {IW{1'b0}}} : {1'b0, IW'(NREC)};

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_WB} st_t;

  st_t           st;
  logic [RW-1:0] tbl [NREC];
  logic [IW-1:0] cur;
  logic [DW-1:0] dat;

  wire [RW-1:0] rec     = tbl[cur];
  wire          r_mode  = rec[RW-1];
  wire          r_chain = rec[RW-2];
  wire          r_rie   = rec[RW-3];
  wire          r_sinc  = rec[RW-4];
  wire          r_dinc  = rec[RW-5];
  wire [CW-1:0] r_cnt   = rec[2*AW+2*CW-1 -: CW];
  wire [CW-1:0] r_rsz   = rec[2*AW+CW-1 -: CW];
  wire [AW-1:0] r_src   = rec[2*AW-1 -: AW];
  wire [AW-1:0] r_dst   = rec[AW-1:0];

  wire [CW-1:0] cnt_dec = r_cnt - 1'b1;
  wire          zero    = (cnt_dec == '0);
  wire          reload  = r_mode & zero;
  wire [AW-1:0] span    = (r_rsz == '0) ? AW'(2**CW) : AW'(r_rsz);
  wire [AW-1:0] src_inc = r_src + 1'b1;
  wire [AW-1:0] dst_inc = r_dst + 1'b1;
  wire [AW-1:0] src_n   = !r_sinc ? r_src : (reload ? src_inc - span : src_inc);
  wire [AW-1:0] dst_n   = !r_dinc ? r_dst : (reload ? dst_inc - span : dst_inc);
  wire [CW-1:0] cnt_n   = reload ? r_rsz : cnt_dec;
  wire [RW-1:0] new_rec = {rec[RW-1 -: 5], cnt_n, r_rsz, src_n, dst_n};
  wire [IW-1:0] nxt_idx = ({1'b0, cur} == NLIM - 1'b1) ? '0 : cur + 1'b1;

  wire act_ok = act_valid && ({1'b0, act_idx} < NLIM);
  wire cfg_ok = cfg_we && ({1'b0, cfg_idx} < NLIM);

  assign cfg_rdata = ({1'b0, cfg_idx} < NLIM) ? tbl[cfg_idx] : '0;
  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? r_dst : r_src;
  assign mem_wdata = dat;
  assign done      = (st == S_WB) && !r_chain;
  assign eoc       = (st == S_WB) && zero && (!r_mode || r_rie);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cur <= '0;
      dat <= '0;
      for (int i = 0; i < NREC; i++) tbl[i] <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (act_ok) begin
            cur <= act_idx;
            st  <= S_RD;
          end else if (cfg_ok) begin
            tbl[cfg_idx] <= cfg_wdata;
          end
        end
        S_RD: if (mem_ready) begin
          dat <= mem_rdata;
          st  <= S_WR;
        end
        S_WR: if (mem_ready) st <= S_WB;
        S_WB: begin
          tbl[cur] <= new_rec;
          if (r_chain) begin
            cur <= nxt_idx;
            st  <= S_RD;
          end else begin
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_ctl_chk.sv
module xfer_ctl_chk #(
  parameter int NREC = 24,
  parameter int IW   = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          act_valid,
  input logic [IW-1:0] act_idx,
  input logic          busy,
  input logic          done,
  input logic          eoc,
  input logic          mem_req,
  input logic          mem_we
);
  localparam logic [IW:0] LIM = (IW+1)'(NREC);

  // R9
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  // R9
  done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R6
  eoc_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) eoc |-> busy);
  // R4
  we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_req);
  // R4
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  // R3
  start_needs_act_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(act_valid));
  // R3
  bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && act_valid && ({1'b0, act_idx} >= LIM)) |=> !busy);
endmodule

bind xfer_ctl xfer_ctl_chk #(.NREC(NREC), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_idx(act_idx),
  .busy(busy), .done(done), .eoc(eoc), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/xfer_ctl_tb.sv
module xfer_ctl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        act_valid = 0;
  logic [4:0]  act_idx = 0;
  logic        cfg_we = 0;
  logic [4:0]  cfg_idx = 0;
  logic [52:0] cfg_wdata = 0;
  logic [52:0] cfg_rdata;
  logic        mem_req, mem_we, mem_ready = 0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done, eoc;

  logic [7:0]  mem  [65536];
  logic [7:0]  emem [65536];
  logic [52:0] rtab [24];
  int total = 0, bad = 0;
  int dq[$];
  int iq[$];

  always #10 clk = ~clk;

  xfer_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_idx(act_idx),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done), .eoc(eoc)
  );

  assign mem_rdata = mem[mem_addr];
  always @(negedge clk) mem_ready <= mem_req && ($urandom_range(0, 2) != 0);
  always @(posedge clk) if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [52:0] mk(input bit md, input bit ch, input bit ri, input bit si,
      input bit di, input logic [7:0] c, input logic [7:0] rs, input logic [15:0] s, input logic [15:0] d);
    return {md, ch, ri, si, di, c, rs, s, d};
  endfunction

  function automatic logic [52:0] upd(input logic [52:0] r, output bit e);
    logic [7:0] cd; logic [15:0] sp, s, d; bit z, rl;
    cd = r[47:40] - 8'd1;
    z  = (cd == 0);
    rl = r[52] && z;
    sp = (r[39:32] == 0) ? 16'd256 : {8'd0, r[39:32]};
    s  = r[31:16]; d = r[15:0];
    if (r[49]) s = rl ? s + 16'd1 - sp : s + 16'd1;
    if (r[48]) d = rl ? d + 16'd1 - sp : d + 16'd1;
    e  = z && (!r[52] || r[50]);
    return {r[52:48], rl ? r[39:32] : cd, r[39:32], s, d};
  endfunction

  task automatic ref_run(input int idx, output int ne);
    int i; bit e;
    i = idx; ne = 0;
    dq.delete(); iq.delete();
    forever begin
      emem[rtab[i][15:0]] = emem[rtab[i][31:16]];
      dq.push_back(int'(rtab[i][15:0]));
      iq.push_back(i);
      rtab[i] = upd(rtab[i], e);
      if (e) ne++;
      if (!rtab[i][51]) break;
      i = (i == 23) ? 0 : i + 1;
    end
  endtask

  task automatic wr_rec(input int i, input logic [52:0] r);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(i); cfg_wdata = r;
    @(negedge clk);
    cfg_we = 0;
    rtab[i] = r;
  endtask

  task automatic rd_rec(input int i, output logic [52:0] r);
    @(negedge clk);
    cfg_idx = 5'(i);
    #1 r = cfg_rdata;
  endtask

  task automatic run_act(input int idx, input bit intr, input int oidx,
                         output int ne, output int nd, output bit bbad);
    int cyc;
    ne = 0; nd = 0; bbad = 0; cyc = 0;
    @(negedge clk);
    act_valid = 1; act_idx = 5'(idx);
    @(negedge clk);
    act_valid = 0; cfg_we = 0;
    forever begin
      if (!busy) begin bbad = 1; break; end
      if (eoc) ne++;
      if (done) begin nd++; break; end
      if (intr && cyc == 0) begin
        act_valid = 1; act_idx = 5'(oidx);
        cfg_we = 1; cfg_idx = 5'(oidx); cfg_wdata = 53'h1F_FFFF_FFFF_FFFF;
      end else begin
        act_valid = 0; cfg_we = 0;
      end
      @(negedge clk);
      cyc++;
      if (cyc > 3000) begin bbad = 1; break; end
    end
    act_valid = 0; cfg_we = 0;
    @(negedge clk);
    if (busy) bbad = 1;
  endtask

  task automatic act_and_check(input int idx, input string req, input bit intr, input int oidx);
    int ne, nd, ene; bit bb; logic [52:0] r;
    run_act(idx, intr, oidx, ne, nd, bb);
    ref_run(idx, ene);
    chk(!bb, "R9", "busy window", 64'(bb), 0);
    chk(nd == 1, "R9", "done pulses", 64'(nd), 1);
    chk(ne == ene, req, "eoc pulses", 64'(ne), 64'(ene));
    foreach (dq[k]) chk(mem[dq[k]] == emem[dq[k]], "R4", "dest byte", 64'(mem[dq[k]]), 64'(emem[dq[k]]));
    foreach (iq[k]) begin
      rd_rec(iq[k], r);
      chk(r == rtab[iq[k]], req, "record write-back", 64'(r), 64'(rtab[iq[k]]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [52:0] r;
    void'($urandom(32'd4242));
    for (int a = 0; a < 65536; a++) begin
      mem[a] = 8'($urandom);
      emem[a] = mem[a];
    end
    for (int i = 0; i < 24; i++) rtab[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !eoc && !mem_req, "R1", "outputs in reset", {busy, done, eoc, mem_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !eoc && !mem_req, "R1", "outputs after reset", {busy, done, eoc, mem_req}, 0);
    rd_rec(7, r);
    chk(r == 0, "R1", "record cleared", 64'(r), 0);

    // R2: record port write and read-back
    wr_rec(3, mk(0, 0, 0, 1, 1, 8'd1, 8'd0, 16'h0010, 16'h0020));
    rd_rec(3, r);
    chk(r == 53'h03_0100_0010_0020, "R2", "record read-back", 64'(r), 64'h03_0100_0010_0020);
    rd_rec(26, r);
    chk(r == 0, "R2", "out-of-range read", 64'(r), 0);

    // R6 R5 R4: normal, count 1 ends
    act_and_check(3, "R6", 0, 0);
    rd_rec(3, r);
    chk(r[47:40] == 0 && r[31:16] == 16'h0011 && r[15:0] == 16'h0021, "R5", "addresses stepped",
        64'(r[31:0]), 64'h0011_0021);

    // R6: count 0 treated as 256, fixed addresses
    wr_rec(4, mk(0, 0, 0, 0, 0, 8'd0, 8'd0, 16'h0030, 16'h0040));
    act_and_check(4, "R6", 0, 0);
    rd_rec(4, r);
    chk(r[47:40] == 8'd255 && r[31:16] == 16'h0030, "R6", "wrap count", 64'(r[47:16]), 64'hFF00_0030);

    // R7: repeat without end-of-count enable, reload and restore
    wr_rec(5, mk(1, 0, 0, 1, 0, 8'd1, 8'd3, 16'h0100, 16'h0200));
    act_and_check(5, "R7", 0, 0);
    rd_rec(5, r);
    chk(r[47:40] == 8'd3 && r[31:16] == 16'h00FE && r[15:0] == 16'h0200, "R7", "reload+restore",
        64'({r[47:40], r[31:0]}), 64'h03_00FE_0200);
    // R7: repeat with end-of-count enable
    wr_rec(6, mk(1, 0, 1, 0, 1, 8'd1, 8'd2, 16'h0300, 16'h0400));
    act_and_check(6, "R7", 0, 0);

    // R8: three-record chain
    wr_rec(10, mk(0, 1, 0, 1, 1, 8'd1, 8'd0, 16'h0500, 16'h0600));
    wr_rec(11, mk(1, 1, 1, 1, 1, 8'd1, 8'd4, 16'h0600, 16'h0700));
    wr_rec(12, mk(0, 0, 0, 0, 1, 8'd5, 8'd0, 16'h0700, 16'h0800));
    act_and_check(10, "R8", 0, 0);
    // R8: chain wraps 23 -> 0
    wr_rec(23, mk(0, 1, 0, 0, 0, 8'd2, 8'd0, 16'h0900, 16'h0A00));
    wr_rec(0,  mk(0, 0, 0, 0, 0, 8'd1, 8'd0, 16'h0A00, 16'h0B00));
    act_and_check(23, "R8", 0, 0);

    // R3 R10: activation and record write while busy ignored
    wr_rec(15, mk(0, 0, 0, 1, 1, 8'd9, 8'd0, 16'h0C00, 16'h0D00));
    wr_rec(16, mk(0, 0, 0, 1, 1, 8'd7, 8'd0, 16'h0E00, 16'h0F00));
    act_and_check(15, "R3", 1, 16);
    rd_rec(16, r);
    chk(r == rtab[16], "R10", "record untouched while busy", 64'(r), 64'(rtab[16]));

    // R3: out-of-range activation
    @(negedge clk); act_valid = 1; act_idx = 5'd25;
    @(negedge clk); act_valid = 0;
    chk(!busy, "R3", "bad index ignored", 64'(busy), 0);
    @(negedge clk);
    chk(!busy && !mem_req, "R3", "still idle", {busy, mem_req}, 0);

    // random mix
    for (int it = 0; it < 150; it++) begin
      int i; logic [52:0] nr;
      for (int w = 0; w < 3; w++) begin
        i = $urandom_range(0, 23);
        nr = mk($urandom_range(0, 1), (i % 4 == 3) ? 1'b0 : ($urandom_range(0, 2) == 0),
                $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                8'($urandom_range(0, 4)), 8'($urandom_range(0, 5)),
                16'($urandom_range(0, 511)), 16'($urandom_range(0, 511)));
        wr_rec(i, nr);
      end
      act_and_check($urandom_range(0, 23), "R8", 0, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule